// File: doc/BRIEF.md
# SDRAM Command Timing Generator

This block sits behind a request arbiter and turns one accepted memory access into the command sequence for an SDRAM device. An access is a read or a write to a linear address. The block splits the address into bank, row and column fields. It issues ACTIVATE with the row on the shared address bus. After a parameterised row-to-column delay it issues a read or write with auto-precharge, with the column on the bus. It drives NOP on every other cycle.

Spacing comes from three shift-register timers. The first fires ACTIVATE. The second places the column command. The third is a thermometer that spans the whole operation. Its low bit is the busy flag, which the arbiter watches before it offers the next request. The same thermometer produces the output enable for the write-data tristate, which is asserted only during the data beats of a write burst.

Top module: `sdram_cmd_timer`

## Requirements
- R1: While reset is asserted and after it is released, the outputs hold the idle state: command NOP, busy low, write output-enable low, bank and address zero.
- R2: A request is accepted on a clock edge where req_valid is high and busy is low. In the cycle after that edge the block drives ACTIVATE ({cs_n,ras_n,cas_n,we_n}=0011), the row field on sd_a and the bank field on sd_ba.
- R3: Exactly TRCD cycles after the ACTIVATE cycle, the block drives the column command. It is READA (0101) for a read or WRITEA (0100) for a write. The column field sits in the low bits of sd_a, bit 10 of sd_a is high to select auto-precharge, the other bits are zero, and sd_ba carries the bank.
- R4: busy is high from the cycle after acceptance for exactly TRCD+BURST+TAIL cycles, and then falls.
- R5: A req_valid seen while busy is high is ignored. No extra ACTIVATE appears, and the running sequence and its busy window are unchanged.
- R6: On every cycle other than the ACTIVATE and column-command cycles, the command is NOP (0111), with sd_a and sd_ba at zero.
- R7: For a write, wr_oe is high for exactly BURST cycles, starting in the WRITEA cycle. For a read, wr_oe stays low.
- R8: The linear address is laid out as {bank, row, column}, with the bank in the most significant bits and the column in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Accepted request offered by the arbiter |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | Linear address {bank,row,col} |
| busy | output | 1 | Operation in progress |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_a | output | A_W | Multiplexed row/column address |
| wr_oe | output | 1 | Write data tristate enable |

## Verification
The checker watches every cycle for the following properties:
- ACTIVATE and busy follow each acceptance on the next cycle.
- The column command lands exactly TRCD cycles after ACTIVATE, with bit 10 set.
- A request made while busy never produces an ACTIVATE.
- An idle block drives NOP with a zero bus.
- wr_oe never appears outside a busy write.

Some properties can only be shown by the bench's scenarios:
- The row and column values on the bus match the address that was sent.
- busy lasts the full duration.
- OE lasts exactly BURST beats.
- The sequence recovers after a reset in the middle of an operation.
- Back-to-back requests work once busy has fallen.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  // Command pins packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100
  } sd_cmd_e;

  localparam int AUTO_PRE_BIT = 10;
endpackage

// File: rtl/sdram_shift_timer.sv
module sdram_shift_timer #(
  parameter int          W    = 4,
  parameter logic [W-1:0] LOAD = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         en;

  assign en = load | (|q);

  always_comb begin
    if (load) q_d = LOAD;
    else      q_d = q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end
endmodule

// File: rtl/sdram_req_capture.sv
module sdram_req_capture #(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          wr_in,
  input  logic [AW-1:0] addr_in,
  output logic          wr_q,
  output logic [AW-1:0] addr_q
);
  logic          wr_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    wr_d   = wr_q;
    addr_d = addr_q;
    if (take) begin
      wr_d   = wr_in;
      addr_d = addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q   <= wr_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int A_W    = 12,
  parameter int TRCD   = 2,
  parameter int BURST  = 4,
  parameter int OPC    = 9
) (
  input  logic              act_stb,
  input  logic              cas_stb,
  input  logic              wr,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [OPC-1:0]    dur,
  output sd_cmd_e           cmd,
  output logic [BANK_W-1:0] ba,
  output logic [A_W-1:0]    a,
  output logic              oe
);
  localparam int OE_START_BIT = OPC - TRCD;
  localparam int OE_END_BIT   = OPC - TRCD - BURST;

  logic [A_W-1:0] col_word;

  always_comb begin
    col_word = A_W'(col);
    col_word[AUTO_PRE_BIT] = 1'b1;
  end

  always_comb begin
    cmd = CMD_NOP;
    ba  = '0;
    a   = '0;
    if (act_stb) begin
      cmd = CMD_ACT;
      ba  = bank;
      a   = A_W'(row);
    end else if (cas_stb) begin
      cmd = wr ? CMD_WRITE : CMD_READ;
      ba  = bank;
      a   = col_word;
    end
  end

  // Thermometer position selects the write data beats
  assign oe = wr & ~dur[OE_START_BIT] & dur[OE_END_BIT];
endmodule

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int A_W    = 12,
  parameter int TRCD   = 2,
  parameter int BURST  = 4,
  parameter int TAIL   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  output logic                          busy,
  output logic                          cmd_cs_n,
  output logic                          cmd_ras_n,
  output logic                          cmd_cas_n,
  output logic                          cmd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [A_W-1:0]                sd_a,
  output logic                          wr_oe
);
  localparam int AW  = BANK_W + ROW_W + COL_W;
  localparam int OPC = TRCD + BURST + TAIL;
  localparam int CW  = TRCD + 1;

  logic          accept;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [0:0]    act_q;
  logic [CW-1:0] cas_q;
  logic [OPC-1:0] dur_q;
  sd_cmd_e       cmd;

  assign busy   = dur_q[0];
  assign accept = req_valid & ~busy;

  sdram_req_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(accept),
    .wr_in(req_write), .addr_in(req_addr),
    .wr_q(wr_q), .addr_q(addr_q)
  );

  sdram_shift_timer #(.W(1), .LOAD(1'b1)) u_act_tmr (
    .clk(clk), .rst_n(rst_n), .load(accept), .q(act_q)
  );

  sdram_shift_timer #(.W(CW), .LOAD(CW'(1) << TRCD)) u_cas_tmr (
    .clk(clk), .rst_n(rst_n), .load(accept), .q(cas_q)
  );

  sdram_shift_timer #(.W(OPC), .LOAD({OPC{1'b1}})) u_dur_tmr (
    .clk(clk), .rst_n(rst_n), .load(accept), .q(dur_q)
  );

  sdram_cmd_drive #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W),
    .TRCD(TRCD), .BURST(BURST), .OPC(OPC)
  ) u_drv (
    .act_stb(act_q[0]),
    .cas_stb(cas_q[0]),
    .wr(wr_q),
    .bank(addr_q[AW-1 -: BANK_W]),
    .row(addr_q[COL_W +: ROW_W]),
    .col(addr_q[COL_W-1:0]),
    .dur(dur_q),
    .cmd(cmd),
    .ba(sd_ba),
    .a(sd_a),
    .oe(wr_oe)
  );

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;
endmodule

// File: rtl/sdram_cmd_timer_chk.sv
module sdram_cmd_timer_chk #(
  parameter int BANK_W = 2,
  parameter int A_W    = 12,
  parameter int TRCD   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              cmd_cs_n,
  input logic              cmd_ras_n,
  input logic              cmd_cas_n,
  input logic              cmd_we_n,
  input logic [BANK_W-1:0] sd_ba,
  input logic [A_W-1:0]    sd_a,
  input logic              wr_oe
);
  logic [3:0] pins;
  logic       is_act, is_col, is_nop, is_rd;
  logic [7:0] since_act;

  assign pins   = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  assign is_act = (pins == 4'b0011);
  assign is_rd  = (pins == 4'b0101);
  assign is_col = is_rd || (pins == 4'b0100);
  assign is_nop = (pins == 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_act <= '0;
    else if (is_act)               since_act <= 8'd1;
    else if (since_act != 8'd0 && since_act != 8'hff)
                                   since_act <= since_act + 8'd1;
  end

  p_act_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> is_act);

  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_col_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_act == 8'(TRCD)));

  p_autopre_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> sd_a[10]);

  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !is_act);

  p_idle_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (is_nop && sd_a == '0 && sd_ba == '0));

  p_oe_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oe |-> (busy && !is_rd && !is_act));
endmodule

bind sdram_cmd_timer sdram_cmd_timer_chk #(
  .BANK_W(BANK_W), .A_W(A_W), .TRCD(TRCD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
  .cmd_we_n(cmd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .wr_oe(wr_oe)
);

// File: tb/sdram_cmd_timer_tb.sv
module sdram_cmd_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 2, ROW_W = 12, COL_W = 8, A_W = 12;
  localparam int TRCD = 2, BURST = 4, TAIL = 3;
  localparam int OPC = TRCD + BURST + TAIL;
  localparam int AW  = BANK_W + ROW_W + COL_W;
  localparam int NV  = 6;

  // {write, linear address}
  localparam logic [AW:0] VEC [NV] = '{
    {1'b0, 2'd1, 12'hABC, 8'h5A},
    {1'b1, 2'd2, 12'h123, 8'hFF},
    {1'b1, 2'd0, 12'hFFF, 8'h00},
    {1'b0, 2'd3, 12'h000, 8'h81},
    {1'b1, 2'd3, 12'h7E1, 8'h3C},
    {1'b0, 2'd0, 12'h001, 8'h01}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic busy, cs_n, ras_n, cas_n, we_n, wr_oe;
  logic [BANK_W-1:0] sd_ba;
  logic [A_W-1:0] sd_a;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_timer #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W),
    .TRCD(TRCD), .BURST(BURST), .TAIL(TAIL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .busy(busy), .cmd_cs_n(cs_n), .cmd_ras_n(ras_n),
    .cmd_cas_n(cas_n), .cmd_we_n(we_n), .sd_ba(sd_ba), .sd_a(sd_a),
    .wr_oe(wr_oe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " R6 cmd"}, {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
    check({tag, " R6 a"},   32'(sd_a), 32'd0);
    check({tag, " R6 ba"},  32'(sd_ba), 32'd0);
    check({tag, " R4 busy"}, 32'(busy), 32'd0);
    check({tag, " R7 oe"},  32'(wr_oe), 32'd0);
  endtask

  // Issue one request at a negedge and walk every cycle of the operation.
  // poke_at >= 0 injects a different request at that cycle (R5).
  task automatic run_op(input logic wr, input logic [AW-1:0] addr, input int poke_at);
    logic [BANK_W-1:0] bk;
    logic [ROW_W-1:0]  rw;
    logic [COL_W-1:0]  cl;
    logic [3:0] exp_cmd;
    logic [A_W-1:0] exp_a;
    logic [BANK_W-1:0] exp_ba;
    bk = addr[AW-1 -: BANK_W];   // R8 field layout
    rw = addr[COL_W +: ROW_W];
    cl = addr[COL_W-1:0];
    req_valid = 1'b1; req_write = wr; req_addr = addr;
    @(posedge clk);
    for (int k = 0; k <= OPC; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (k == 0) begin exp_cmd = 4'b0011; exp_a = A_W'(rw); exp_ba = bk; end
      else if (k == TRCD) begin
        exp_cmd = wr ? 4'b0100 : 4'b0101;
        exp_a = A_W'(cl) | (A_W'(1) << 10);
        exp_ba = bk;
      end else begin exp_cmd = 4'b0111; exp_a = '0; exp_ba = '0; end
      check((k == 0) ? "R2 act cmd" : (k == TRCD) ? "R3 col cmd" : "R6 nop cmd",
            {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, exp_cmd});
      check((k == 0) ? "R2/R8 row addr" : (k == TRCD) ? "R3/R8 col addr" : "R6 addr",
            32'(sd_a), 32'(exp_a));
      check("R2/R3 bank", 32'(sd_ba), 32'(exp_ba));
      check("R4 busy", 32'(busy), 32'(k < OPC));
      check("R7 oe", 32'(wr_oe), 32'(wr && k >= TRCD && k < TRCD + BURST));
      if (k == poke_at) begin
        req_valid = 1'b1; req_write = ~wr; req_addr = ~addr;   // R5 ignored
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    #(CLK_PERIOD * 2 + 1);
    check_idle("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int i = 0; i < NV; i++) run_op(VEC[i][AW], VEC[i][AW-1:0], -1);

    // R5: requests while busy, at several points of the sequence
    run_op(1'b1, {2'd2, 12'h5A5, 8'hC3}, 1);
    run_op(1'b0, {2'd1, 12'h0F0, 8'h0F}, TRCD);
    run_op(1'b1, {2'd3, 12'hA5A, 8'h77}, OPC - 1);
    @(negedge clk);
    check_idle("R5 after ignored req");

    // Reset in the middle of a write burst
    req_valid = 1'b1; req_write = 1'b1; req_addr = {2'd1, 12'h333, 8'h44};
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    repeat (TRCD + 1) @(negedge clk);
    rst_n = 1'b0; #1;
    check_idle("R1 mid-op reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 post mid-op reset");
    run_op(1'b0, {2'd0, 12'h800, 8'h80}, -1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule